// File: doc/BRIEF.md
# Immediate-Prefix Instruction Decoder

This block turns a stream of 16-bit fixed-length instruction words into decoded control records: register indices, an ALU operation code, memory and flow-control strobes, a branch condition and a fully formed 16-bit immediate. The opcode is the top nibble. The other three nibbles hold register indices, a function selector or immediate fields, depending on which of the six formats the opcode selects. The formats are three-register, register-register-immediate, two-operand register, two-operand immediate, 12-bit immediate and branch.

A prefix instruction (opcode D) carries twelve bits. These become bits 15:4 of the immediate of the very next instruction, and that instruction's own low nibble supplies bits 3:0. The prefix is one-shot: any instruction that follows it consumes it, whether or not that instruction takes an immediate. The decoder also flags the instructions that must not be split from their successor by an interrupt.

Instructions enter on a valid/ready handshake and leave through one registered output stage with its own valid/ready pair. A word is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output record holds still and no new word is accepted. The prefix state advances only on accepted words.

Top module: `insn_prefix_decoder`

## Requirements
- R1: `out_rd`, `out_ra` and `out_rb` come from bits 11:8, 7:4 and 3:0. For opcodes 3 and 4, `out_ra` equals the destination (bits 11:8). For opcode C, `out_rd` is 15. `out_cond` is always bits 11:8.
- R2: Opcodes 2 (addi) and 4 (register-immediate op) sign-extend the 4-bit field to 16 bits, giving -8..7. Without a pending prefix, opcodes 0, 1, 3, 7, E and F produce an immediate of 0.
- R3: Opcodes 6 (load byte) and 9 (store byte) zero-extend the 4-bit field, giving 0..15.
- R4: Opcodes 5 (load word), 8 (store word) and A (jump-and-link) give the 4-bit field times two, zero-extended.
- R5: Opcode C (call) gives an immediate of bits 11:0 shifted left by 4, sets `out_rd` to 15 and asserts `out_call` and `out_reg_we`.
- R6: Opcode B (branch) asserts `out_branch`. Its immediate is the sign-extended 8-bit displacement in bits 7:0, times two.
- R7: After a prefix (opcode D), the next accepted instruction of opcodes 2, 4, 5, 6, 8, 9 or A gets the immediate {prefix bits 11:0, own bits 3:0}, with no scaling, and asserts `out_pfx_used`. A prefix's own record carries the immediate {bits 11:0, 4'h0}.
- R8: A prefix is cleared by exactly one following accepted instruction of any opcode. Calls and branches ignore it. A second prefix replaces it.
- R9: `out_no_irq` is high for opcodes 0, 1 and D, for opcode 3 with fn 4 or 5, and for opcode 4 with fn 4 to 10.
- R10: Opcodes 7, E and F, opcode 3 with fn above 5 and opcode 4 with fn above 10 assert `out_illegal`. They also force `out_alu_fn` to 0 and every write, memory and flow strobe low.
- R11: `out_reg_we` is high for opcodes 0 to 6, A and C with a legal fn, and never when `out_rd` is 0.
- R12: `in_ready` equals `!out_valid || out_ready`. A stalled output record stays unchanged. An accepted word appears on the outputs one clock later.
- R13: While `rst_n` is low, `out_valid` is low and any pending prefix is discarded.
- R14: `out_alu_fn` is 0 for add, addi, loads, stores, jal, call, branch and prefix, and 1 for sub. For opcodes 3 and 4 it is fn+2, where fn (bits 7:4) means 0 and, 1 or, 2 xor, 3 andn, 4 adc, 5 sbc, 6 sll, 7 slx, 8 sra, 9 srl, 10 srx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_insn | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_rd | output | 4 | Destination register index |
| out_ra | output | 4 | First source register index |
| out_rb | output | 4 | Second source register index |
| out_alu_fn | output | 4 | ALU operation code |
| out_imm | output | 16 | Formed immediate |
| out_cond | output | 4 | Branch condition field |
| out_use_imm | output | 1 | Second operand is the immediate |
| out_reg_we | output | 1 | Register write |
| out_mem_rd | output | 1 | Memory load |
| out_mem_wr | output | 1 | Memory store |
| out_mem_byte | output | 1 | Byte-sized access |
| out_jump | output | 1 | Register-relative jump with link |
| out_call | output | 1 | Absolute call with link to r15 |
| out_branch | output | 1 | Conditional PC-relative branch |
| out_no_irq | output | 1 | Do not interrupt before the next instruction |
| out_illegal | output | 1 | Reserved opcode or function |
| out_pfx_used | output | 1 | Immediate took its upper bits from a prefix |

## Verification
The hardest situation to reach is a prefix that sits pending while the output is stalled. Its consumer is offered but not accepted, so a mistake in tying the prefix update to the handshake would drop or reuse the prefix. The stimulus holds `out_ready` low right after a prefix while offering the consuming word for several cycles, then releases it. Sequences of a prefix followed by a non-immediate instruction, a call, a reserved opcode or a second prefix check that the prefix is consumed exactly once, and a reset between a prefix and its consumer checks that the prefix is discarded.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

  localparam int INSN_W = 16;
  localparam int IDX_W  = 4;
  localparam int FLD_W  = 4;
  localparam int PFX_W  = INSN_W - FLD_W;
  localparam int DISP_W = 8;
  localparam int ALU_W  = 4;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_ADDI = 4'h2;
  localparam logic [3:0] OP_RR   = 4'h3;
  localparam logic [3:0] OP_RI   = 4'h4;
  localparam logic [3:0] OP_LDW  = 4'h5;
  localparam logic [3:0] OP_LDB  = 4'h6;
  localparam logic [3:0] OP_STW  = 4'h8;
  localparam logic [3:0] OP_STB  = 4'h9;
  localparam logic [3:0] OP_JAL  = 4'hA;
  localparam logic [3:0] OP_BR   = 4'hB;
  localparam logic [3:0] OP_CALL = 4'hC;
  localparam logic [3:0] OP_PFX  = 4'hD;

  localparam logic [3:0] FN_RR_MAX  = 4'd5;
  localparam logic [3:0] FN_RI_MAX  = 4'd10;
  localparam logic [3:0] FN_CARRY   = 4'd4;
  localparam logic [ALU_W-1:0] ALU_ADD = 4'd0;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'd1;
  localparam logic [ALU_W-1:0] ALU_FN_BASE = 4'd2;

  typedef enum logic [2:0] {
    IK_NONE,
    IK_S4,
    IK_U4,
    IK_W4,
    IK_CALL,
    IK_BR,
    IK_PFX
  } imm_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  ra;
    logic [IDX_W-1:0]  rb;
    logic [ALU_W-1:0]  alu_fn;
    logic [INSN_W-1:0] imm;
    logic [FLD_W-1:0]  cond;
    logic              use_imm;
    logic              reg_we;
    logic              mem_rd;
    logic              mem_wr;
    logic              mem_byte;
    logic              jump;
    logic              call;
    logic              branch;
    logic              no_irq;
    logic              illegal;
    logic              pfx_used;
  } dec_t;

endpackage

// File: rtl/ipd_prefix_reg.sv
module ipd_prefix_reg
  import ipd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [INSN_W-1:0] insn,
  output logic              pfx_valid,
  output logic [PFX_W-1:0]  pfx_val
);

  logic is_pfx;
  assign is_pfx = (insn[INSN_W-1 -: 4] == OP_PFX);

  // One-shot: every accepted word either loads a new prefix or consumes the old one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_valid <= 1'b0;
      pfx_val   <= '0;
    end else if (take) begin
      pfx_valid <= is_pfx;
      if (is_pfx) pfx_val <= insn[PFX_W-1:0];
    end
  end

endmodule

// File: rtl/ipd_field_dec.sv
module ipd_field_dec
  import ipd_pkg::*;
#(
  parameter int LINK_REG = 15
) (
  input  logic [INSN_W-1:0] insn,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  ra,
  output logic [IDX_W-1:0]  rb,
  output logic [ALU_W-1:0]  alu_fn,
  output logic [FLD_W-1:0]  cond,
  output imm_kind_e         kind,
  output logic              use_imm,
  output logic              reg_we,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_byte,
  output logic              jump,
  output logic              call,
  output logic              branch,
  output logic              no_irq,
  output logic              illegal
);

  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

  logic [3:0] op;
  logic [3:0] fn;
  logic       we_raw;

  assign op = insn[15:12];
  assign fn = insn[7:4];

  always_comb begin
    rd       = insn[11:8];
    ra       = insn[7:4];
    rb       = insn[3:0];
    cond     = insn[11:8];
    alu_fn   = ALU_ADD;
    kind     = IK_NONE;
    we_raw   = 1'b0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    mem_byte = 1'b0;
    jump     = 1'b0;
    call     = 1'b0;
    branch   = 1'b0;
    no_irq   = 1'b0;
    illegal  = 1'b0;
    unique case (op)
      OP_ADD: begin
        we_raw = 1'b1;
        no_irq = 1'b1;
      end
      OP_SUB: begin
        we_raw = 1'b1;
        alu_fn = ALU_SUB;
        no_irq = 1'b1;
      end
      OP_ADDI: begin
        we_raw = 1'b1;
        kind   = IK_S4;
      end
      OP_RR: begin
        ra = insn[11:8];
        if (fn <= FN_RR_MAX) begin
          we_raw = 1'b1;
          alu_fn = fn + ALU_FN_BASE;
          no_irq = (fn >= FN_CARRY);
        end else begin
          illegal = 1'b1;
        end
      end
      OP_RI: begin
        ra = insn[11:8];
        if (fn <= FN_RI_MAX) begin
          we_raw = 1'b1;
          alu_fn = fn + ALU_FN_BASE;
          kind   = IK_S4;
          no_irq = (fn >= FN_CARRY);
        end else begin
          illegal = 1'b1;
        end
      end
      OP_LDW: begin
        we_raw = 1'b1;
        mem_rd = 1'b1;
        kind   = IK_W4;
      end
      OP_LDB: begin
        we_raw   = 1'b1;
        mem_rd   = 1'b1;
        mem_byte = 1'b1;
        kind     = IK_U4;
      end
      OP_STW: begin
        mem_wr = 1'b1;
        kind   = IK_W4;
      end
      OP_STB: begin
        mem_wr   = 1'b1;
        mem_byte = 1'b1;
        kind     = IK_U4;
      end
      OP_JAL: begin
        we_raw = 1'b1;
        jump   = 1'b1;
        kind   = IK_W4;
      end
      OP_BR: begin
        branch = 1'b1;
        kind   = IK_BR;
      end
      OP_CALL: begin
        rd     = LINK_IDX;
        we_raw = 1'b1;
        call   = 1'b1;
        kind   = IK_CALL;
      end
      OP_PFX: begin
        no_irq = 1'b1;
        kind   = IK_PFX;
      end
      default: illegal = 1'b1;
    endcase
  end

  assign reg_we  = we_raw && (rd != '0);
  assign use_imm = (kind == IK_S4) || (kind == IK_U4) || (kind == IK_W4);

endmodule

// File: rtl/ipd_imm_gen.sv
module ipd_imm_gen
  import ipd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  imm_kind_e         kind,
  input  logic              pfx_valid,
  input  logic [PFX_W-1:0]  pfx_val,
  output logic [INSN_W-1:0] imm,
  output logic              pfx_used
);

  logic [FLD_W-1:0]  fld;
  logic [DISP_W-1:0] disp;
  logic              short_field;

  assign fld  = insn[FLD_W-1:0];
  assign disp = insn[DISP_W-1:0];
  assign short_field = (kind == IK_S4) || (kind == IK_U4) || (kind == IK_W4);
  assign pfx_used    = short_field && pfx_valid;

  always_comb begin
    if (pfx_used) begin
      imm = {pfx_val, fld};
    end else begin
      unique case (kind)
        IK_S4:   imm = {{(INSN_W-FLD_W){fld[FLD_W-1]}}, fld};
        IK_U4:   imm = {{(INSN_W-FLD_W){1'b0}}, fld};
        IK_W4:   imm = {{(INSN_W-FLD_W-1){1'b0}}, fld, 1'b0};
        IK_CALL: imm = {insn[PFX_W-1:0], {FLD_W{1'b0}}};
        IK_BR:   imm = {{(INSN_W-DISP_W-1){disp[DISP_W-1]}}, disp, 1'b0};
        IK_PFX:  imm = {insn[PFX_W-1:0], {FLD_W{1'b0}}};
        default: imm = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipd_out_stage.sv
module ipd_out_stage
  import ipd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  dec_t in_rec,
  output logic out_valid,
  input  logic out_ready,
  output dec_t out_rec
);

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) out_rec <= in_rec;
    end
  end

endmodule

// File: rtl/insn_prefix_decoder.sv
module insn_prefix_decoder
  import ipd_pkg::*;
#(
  parameter int LINK_REG = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_insn,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_rd,
  output logic [3:0]  out_ra,
  output logic [3:0]  out_rb,
  output logic [3:0]  out_alu_fn,
  output logic [15:0] out_imm,
  output logic [3:0]  out_cond,
  output logic        out_use_imm,
  output logic        out_reg_we,
  output logic        out_mem_rd,
  output logic        out_mem_wr,
  output logic        out_mem_byte,
  output logic        out_jump,
  output logic        out_call,
  output logic        out_branch,
  output logic        out_no_irq,
  output logic        out_illegal,
  output logic        out_pfx_used
);

  logic             take;
  logic             pfx_valid;
  logic [PFX_W-1:0] pfx_val;
  imm_kind_e        kind;
  dec_t             rec_d;
  dec_t             rec_q;

  assign take = in_valid && in_ready;

  ipd_prefix_reg u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .insn      (in_insn),
    .pfx_valid (pfx_valid),
    .pfx_val   (pfx_val)
  );

  ipd_field_dec #(.LINK_REG(LINK_REG)) u_fields (
    .insn     (in_insn),
    .rd       (rec_d.rd),
    .ra       (rec_d.ra),
    .rb       (rec_d.rb),
    .alu_fn   (rec_d.alu_fn),
    .cond     (rec_d.cond),
    .kind     (kind),
    .use_imm  (rec_d.use_imm),
    .reg_we   (rec_d.reg_we),
    .mem_rd   (rec_d.mem_rd),
    .mem_wr   (rec_d.mem_wr),
    .mem_byte (rec_d.mem_byte),
    .jump     (rec_d.jump),
    .call     (rec_d.call),
    .branch   (rec_d.branch),
    .no_irq   (rec_d.no_irq),
    .illegal  (rec_d.illegal)
  );

  ipd_imm_gen u_imm (
    .insn      (in_insn),
    .kind      (kind),
    .pfx_valid (pfx_valid),
    .pfx_val   (pfx_val),
    .imm       (rec_d.imm),
    .pfx_used  (rec_d.pfx_used)
  );

  ipd_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_rec    (rec_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rec   (rec_q)
  );

  assign out_rd       = rec_q.rd;
  assign out_ra       = rec_q.ra;
  assign out_rb       = rec_q.rb;
  assign out_alu_fn   = rec_q.alu_fn;
  assign out_imm      = rec_q.imm;
  assign out_cond     = rec_q.cond;
  assign out_use_imm  = rec_q.use_imm;
  assign out_reg_we   = rec_q.reg_we;
  assign out_mem_rd   = rec_q.mem_rd;
  assign out_mem_wr   = rec_q.mem_wr;
  assign out_mem_byte = rec_q.mem_byte;
  assign out_jump     = rec_q.jump;
  assign out_call     = rec_q.call;
  assign out_branch   = rec_q.branch;
  assign out_no_irq   = rec_q.no_irq;
  assign out_illegal  = rec_q.illegal;
  assign out_pfx_used = rec_q.pfx_used;

endmodule

// File: rtl/ipd_checker.sv
module ipd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_insn,
  input logic        out_valid,
  input logic        out_ready,
  input logic [3:0]  out_rd,
  input logic [3:0]  out_ra,
  input logic [3:0]  out_rb,
  input logic [3:0]  out_alu_fn,
  input logic [15:0] out_imm,
  input logic [3:0]  out_cond,
  input logic        out_use_imm,
  input logic        out_reg_we,
  input logic        out_mem_rd,
  input logic        out_mem_wr,
  input logic        out_mem_byte,
  input logic        out_jump,
  input logic        out_call,
  input logic        out_branch,
  input logic        out_no_irq,
  input logic        out_illegal,
  input logic        out_pfx_used
);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_imm) && $stable(out_rd)
                                && $stable(out_alu_fn) && $stable(out_pfx_used));

  // R12
  accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_reg_we && !out_mem_rd && !out_mem_wr
                                 && !out_jump && !out_call && !out_branch);

  // R11
  no_r0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reg_we |-> out_rd != 4'd0);

  // R5
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_call |-> out_rd == 4'd15 && out_imm[3:0] == 4'd0 && out_reg_we);

  // R7
  pfx_only_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_pfx_used |-> out_use_imm);

  // R4
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mem_rd && !out_mem_byte && !out_pfx_used |-> out_imm[0] == 1'b0);

endmodule

bind insn_prefix_decoder ipd_checker u_chk (.*);

// File: tb/sim_insn_prefix_decoder.sv
module sim_insn_prefix_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_insn;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_rd, out_ra, out_rb, out_alu_fn, out_cond;
  logic [15:0] out_imm;
  logic        out_use_imm, out_reg_we, out_mem_rd, out_mem_wr, out_mem_byte;
  logic        out_jump, out_call, out_branch, out_no_irq, out_illegal, out_pfx_used;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  insn_prefix_decoder u0 (.*);

  // {insn, imm, rd, ra, rb, alu, flags{use_imm,we,mrd,mwr,mbyte,jump,call,branch,no_irq,illegal}, pfx_used}
  localparam int N = 39;
  localparam logic [58:0] VEC [N] = '{
    {16'h0123, 16'h0000, 4'h1, 4'h2, 4'h3, 4'd0, 10'b0100000010, 1'b0},
    {16'h1456, 16'h0000, 4'h4, 4'h5, 4'h6, 4'd1, 10'b0100000010, 1'b0},
    {16'h2A3F, 16'hFFFF, 4'hA, 4'h3, 4'hF, 4'd0, 10'b1100000000, 1'b0},
    {16'h2127, 16'h0007, 4'h1, 4'h2, 4'h7, 4'd0, 10'b1100000000, 1'b0},
    {16'h3702, 16'h0000, 4'h7, 4'h7, 4'h2, 4'd2, 10'b0100000000, 1'b0},
    {16'h3845, 16'h0000, 4'h8, 4'h8, 4'h5, 4'd6, 10'b0100000010, 1'b0},
    {16'h3960, 16'h0000, 4'h9, 4'h9, 4'h0, 4'd0, 10'b0000000001, 1'b0},
    {16'h4B68, 16'hFFF8, 4'hB, 4'hB, 4'h8, 4'd8, 10'b1100000010, 1'b0},
    {16'h4C1F, 16'hFFFF, 4'hC, 4'hC, 4'hF, 4'd3, 10'b1100000000, 1'b0},
    {16'h4DB0, 16'h0000, 4'hD, 4'hD, 4'h0, 4'd0, 10'b0000000001, 1'b0},
    {16'h5129, 16'h0012, 4'h1, 4'h2, 4'h9, 4'd0, 10'b1110000000, 1'b0},
    {16'h634F, 16'h000F, 4'h3, 4'h4, 4'hF, 4'd0, 10'b1110100000, 1'b0},
    {16'h8561, 16'h0002, 4'h5, 4'h6, 4'h1, 4'd0, 10'b1001000000, 1'b0},
    {16'h9780, 16'h0000, 4'h7, 4'h8, 4'h0, 4'd0, 10'b1001100000, 1'b0},
    {16'hA0F3, 16'h0006, 4'h0, 4'hF, 4'h3, 4'd0, 10'b1000010000, 1'b0},
    {16'hAE12, 16'h0004, 4'hE, 4'h1, 4'h2, 4'd0, 10'b1100010000, 1'b0},
    {16'hB3FE, 16'hFFFC, 4'h3, 4'hF, 4'hE, 4'd0, 10'b0000000100, 1'b0},
    {16'hC123, 16'h1230, 4'hF, 4'h2, 4'h3, 4'd0, 10'b0100001000, 1'b0},
    {16'hD123, 16'h1230, 4'h1, 4'h2, 4'h3, 4'd0, 10'b0000000010, 1'b0},
    {16'h2455, 16'h1235, 4'h4, 4'h5, 4'h5, 4'd0, 10'b1100000000, 1'b1},
    {16'h2455, 16'h0005, 4'h4, 4'h5, 4'h5, 4'd0, 10'b1100000000, 1'b0},
    {16'hDABC, 16'hABC0, 4'hA, 4'hB, 4'hC, 4'd0, 10'b0000000010, 1'b0},
    {16'h0123, 16'h0000, 4'h1, 4'h2, 4'h3, 4'd0, 10'b0100000010, 1'b0},
    {16'h2455, 16'h0005, 4'h4, 4'h5, 4'h5, 4'd0, 10'b1100000000, 1'b0},
    {16'hD800, 16'h8000, 4'h8, 4'h0, 4'h0, 4'd0, 10'b0000000010, 1'b0},
    {16'h5127, 16'h8007, 4'h1, 4'h2, 4'h7, 4'd0, 10'b1110000000, 1'b1},
    {16'hDFFF, 16'hFFF0, 4'hF, 4'hF, 4'hF, 4'd0, 10'b0000000010, 1'b0},
    {16'hC010, 16'h0100, 4'hF, 4'h1, 4'h0, 4'd0, 10'b0100001000, 1'b0},
    {16'h6003, 16'h0003, 4'h0, 4'h0, 4'h3, 4'd0, 10'b1010100000, 1'b0},
    {16'hD001, 16'h0010, 4'h0, 4'h0, 4'h1, 4'd0, 10'b0000000010, 1'b0},
    {16'hD002, 16'h0020, 4'h0, 4'h0, 4'h2, 4'd0, 10'b0000000010, 1'b0},
    {16'h2007, 16'h0027, 4'h0, 4'h0, 4'h7, 4'd0, 10'b1000000000, 1'b1},
    {16'h7123, 16'h0000, 4'h1, 4'h2, 4'h3, 4'd0, 10'b0000000001, 1'b0},
    {16'hE000, 16'h0000, 4'h0, 4'h0, 4'h0, 4'd0, 10'b0000000001, 1'b0},
    {16'hD777, 16'h7770, 4'h7, 4'h7, 4'h7, 4'd0, 10'b0000000010, 1'b0},
    {16'hF555, 16'h0000, 4'h5, 4'h5, 4'h5, 4'd0, 10'b0000000001, 1'b0},
    {16'h2110, 16'h0000, 4'h1, 4'h1, 4'h0, 4'd0, 10'b1100000000, 1'b0},
    {16'hD00F, 16'h00F0, 4'h0, 4'h0, 4'hF, 4'd0, 10'b0000000010, 1'b0},
    {16'h4C1F, 16'h00FF, 4'hC, 4'hC, 4'hF, 4'd3, 10'b1100000000, 1'b1}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // One word per call; returns at the negedge where its record is on the outputs.
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_insn = '0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state, R12 ready when empty
    check("R13 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R12 in_ready in reset", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      logic [58:0] v;
      v = VEC[i];
      send(v[58:43]);
      check($sformatf("R12 vec%0d out_valid", i), {15'd0, out_valid}, 16'd1);
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 vec%0d imm", i), out_imm, v[42:27]);
      check($sformatf("R1 R5 vec%0d regs", i), {4'd0, out_rd, out_ra, out_rb}, {4'd0, v[26:15]});
      check($sformatf("R14 vec%0d alu", i), {12'd0, out_alu_fn}, {12'd0, v[14:11]});
      check($sformatf("R9 R10 R11 vec%0d flags", i),
            {6'd0, out_use_imm, out_reg_we, out_mem_rd, out_mem_wr, out_mem_byte,
             out_jump, out_call, out_branch, out_no_irq, out_illegal}, {6'd0, v[10:1]});
      check($sformatf("R7 R8 vec%0d pfx_used", i), {15'd0, out_pfx_used}, {15'd0, v[0]});
    end

    // R6 condition field and forward displacement
    send(16'hB27F);
    check("R6 cond", {12'd0, out_cond}, 16'h0002);
    check("R6 forward disp", out_imm, 16'h00FE);
    send(16'hB980);
    check("R6 cond", {12'd0, out_cond}, 16'h0009);
    check("R6 most negative disp", out_imm, 16'hFF00);

    // R12 stall with a pending prefix; R8 prefix advances only on accepted words
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_insn   = 16'hD345;
    @(posedge clk);
    @(negedge clk);
    in_insn = 16'h2006;
    for (int k = 0; k < 3; k++) begin
      check("R12 in_ready low when stalled", {15'd0, in_ready}, 16'd0);
      check("R12 held record imm", out_imm, 16'h3450);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 R12 prefix after stall", out_imm, 16'h3456);
    check("R7 R12 prefix used after stall", {15'd0, out_pfx_used}, 16'd1);
    @(negedge clk);
    check("R12 drained", {15'd0, out_valid}, 16'd0);

    // R13 reset discards a pending prefix
    send(16'hD9AB);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R13 out_valid during reset", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    send(16'h2001);
    check("R13 prefix discarded imm", out_imm, 16'h0001);
    check("R13 prefix discarded flag", {15'd0, out_pfx_used}, 16'd0);

    finish_run();
  end

endmodule